// File: doc/BRIEF.md
# Multiplexed Bus Front End for Clock Registers and Byte RAM

This block connects a shared 8-bit address/data bus to two independent targets. The first is a 64-byte clock register space. It is addressed through a positive address-latch pulse and accessed with active-low read, write and chip select. The second is a 4096-byte RAM. Its 12-bit address is built from two separate rising-edge strobes, one for the low byte and one for the upper nibble. The RAM has its own active-low output enable and write enable.

All bus pins are sampled on the system clock, and strobe edges are detected from one sample to the next. A write commits on the rising edge of its enable and takes the bus value present on that edge. The tri-state bus is represented by a data output and a drive enable. The clock register space applies read-only masks: the two status bytes are fixed, and the top bit of the rate/control byte is fixed. A single inhibit input stands in for the power-fail write protect. The register storage and the RAM array are behavioural.

Top module: `mux_bus_dual_ram_if`

## Requirements
- R1: A falling edge of `ale` loads the clock register address from `ad_in[5:0]`, so addresses above 63 alias modulo 64. The address is loaded whether or not `cs_n` is low.
- R2: A clock register write commits on a rising edge of `wr_n`, storing `ad_in`. It requires `cs_n` low in both the commit cycle and the cycle before, and `inhibit` low. Without chip select nothing is stored.
- R3: `ad_oe` is high only while (`rd_n` and `cs_n` are both low) or `roe_n` is low, and `inhibit` is low. The clock register read takes priority over the RAM read when both are requested.
- R4: A rising edge of `ras_lo` loads RAM address bits 7:0 from `ad_in`. A rising edge of `ras_hi` loads RAM address bits 11:8 from `ad_in[3:0]`.
- R5: A rising edge of `rwe_n` with `inhibit` low writes `ad_in` to the RAM at the latched address. While `roe_n` is low, that byte appears on `ad_out`.
- R6: Clock register addresses 12 and 13 are read-only. Writes to them leave their values 0x00 and 0x80.
- R7: Bit 7 of clock register address 10 is read-only and reads 0. Bits 6:0 of that register are writable.
- R8: All other clock register addresses (0 to 9, 11, and 14 to 63) store and return the full 8-bit value written.
- R9: While `inhibit` is high, no write reaches either target and `ad_oe` stays low.
- R10: After reset, `ad_oe` is low, both latched addresses are zero, and the clock registers are zero except address 13, which reads 0x80.
- R11: A clock register write commit and a RAM address strobe edge in the same clock cycle both take effect from the same `ad_in` value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock sampling all bus pins |
| rst_n | input | 1 | Synchronous active-low reset |
| ad_in | input | 8 | Bus value seen on the shared address/data pins |
| ad_out | output | 8 | Read data driven onto the bus |
| ad_oe | output | 1 | Bus drive enable (high means driven, low means floating) |
| ale | input | 1 | Clock-side address latch pulse, active on its falling edge |
| rd_n | input | 1 | Clock register read, active low |
| wr_n | input | 1 | Clock register write, commits on its rising edge |
| cs_n | input | 1 | Clock register chip select, active low |
| ras_lo | input | 1 | RAM low address byte strobe, active on its rising edge |
| ras_hi | input | 1 | RAM upper address nibble strobe, active on its rising edge |
| roe_n | input | 1 | RAM output enable, active low |
| rwe_n | input | 1 | RAM write enable, commits on its rising edge |
| inhibit | input | 1 | Power-fail inhibit: blocks writes and bus drive |

## Verification
The clock register write commit and the RAM low address strobe can both sample the shared bus in one clock cycle. The bench provokes this by raising `wr_n` and `ras_lo` at the same drive instant while a single data byte sits on the bus. It then completes the RAM address with the upper strobe and writes a different byte into the RAM. The case passes only if the clock register reads back the shared byte and the RAM location named by that byte plus the upper nibble reads back the RAM byte.

// File: rtl/mbd_pkg.sv
// Package: shared sizes and fixed clock register locations.
// Assumes an 8-bit bus, a 64-byte clock space and a 4 KiB RAM by default.
package mbd_pkg;
    localparam int DATA_W    = 8;
    localparam int RTC_AW    = 6;
    localparam int RAM_AW    = 12;
    localparam int REG_RATE  = 10;          // rate/control byte, bit 7 fixed at 0
    localparam int REG_FLAGS = 12;          // status byte, read-only
    localparam int REG_STAT  = 13;          // status byte, read-only
    localparam logic [DATA_W-1:0] STAT_RST = 8'h80;
    localparam logic [DATA_W-1:0] RATE_WMASK = 8'h7F;
endpackage

// File: rtl/strobe_sampler.sv
// strobe_sampler: holds the previous sample of a group of strobe pins so the
// parent can form edge pulses. Assumes pins are synchronous to clk.
module strobe_sampler #(
    parameter int W = 5,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins,
    output logic [W-1:0] prev
);
    // Purpose: keep last cycle's pin levels, idle levels after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= RST_VAL;
        else        prev <= pins;
    end
endmodule

// File: rtl/rtc_regfile.sv
// rtc_regfile: 64-byte clock register store with read-only masks.
// Assumes a single write port committed by the parent and a combinational read.
module rtc_regfile
    import mbd_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = RTC_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [0:DEPTH-1];
    logic          ro_hit;
    logic          rate_hit;

    assign ro_hit   = (waddr == AW'(REG_FLAGS)) || (waddr == AW'(REG_STAT));
    assign rate_hit = (waddr == AW'(REG_RATE));

    // Purpose: reset contents, then apply masked writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= (i == REG_STAT) ? STAT_RST : '0;
            end
        end else if (we && !ro_hit) begin
            mem[waddr] <= rate_hit ? (wdata & RATE_WMASK) : wdata;
        end
    end

    // Purpose: combinational read of the latched address.
    always_comb rdata = mem[raddr];

    AST_FLAGS_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr == AW'(REG_FLAGS)) |=> (mem[REG_FLAGS] == $past(mem[REG_FLAGS]))); // R6
    AST_STAT_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr == AW'(REG_STAT)) |=> (mem[REG_STAT] == $past(mem[REG_STAT]))); // R6
    AST_RATE_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (we && rate_hit) |=> (mem[REG_RATE][DW-1] == 1'b0)); // R7
endmodule

// File: rtl/byte_ram.sv
// byte_ram: behavioural byte-wide RAM, one write port, combinational read.
// Assumes contents are retained (no reset), as for a backed-up store.
module byte_ram
    import mbd_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = RAM_AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [0:DEPTH-1];

    // Purpose: store a byte when the parent commits a write.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Purpose: present the addressed byte.
    always_comb rdata = mem[raddr];
endmodule

// File: rtl/mux_bus_dual_ram_if.sv
// mux_bus_dual_ram_if: front end joining a multiplexed 8-bit bus to a clock
// register space and a byte RAM. Detects strobe edges on clk, latches both
// addresses, commits writes on enable rising edges, and drives the bus while
// a read enable is low. Assumes bus pins are already synchronous to clk.
module mux_bus_dual_ram_if
    import mbd_pkg::*;
#(
    parameter int DW  = DATA_W,
    parameter int RAW = RTC_AW,
    parameter int MAW = RAM_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] ad_in,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe,
    input  logic          ale,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic          cs_n,
    input  logic          ras_lo,
    input  logic          ras_hi,
    input  logic          roe_n,
    input  logic          rwe_n,
    input  logic          inhibit
);
    localparam int HI_W = MAW - DW;
    localparam int NPIN = 5;
    localparam int P_ALE = 0, P_WR = 1, P_RWE = 2, P_RLO = 3, P_RHI = 4;
    localparam logic [NPIN-1:0] PIN_IDLE = 5'b00110;

    logic [NPIN-1:0] pins, prev;
    logic            cs_n_q;
    logic            ale_fall, wr_rise, rwe_rise, rlo_rise, rhi_rise;
    logic            rtc_we, ram_we, rtc_rd;
    logic [RAW-1:0]  rtc_addr;
    logic [MAW-1:0]  ram_addr;
    logic [DW-1:0]   rtc_rdata, ram_rdata;

    assign pins = {ras_hi, ras_lo, rwe_n, wr_n, ale};

    strobe_sampler #(.W(NPIN), .RST_VAL(PIN_IDLE)) u_samp (
        .clk(clk), .rst_n(rst_n), .pins(pins), .prev(prev)
    );

    // Purpose: edge pulses from previous and present pin levels.
    always_comb begin
        ale_fall = prev[P_ALE] && !ale;
        wr_rise  = !prev[P_WR] && wr_n;
        rwe_rise = !prev[P_RWE] && rwe_n;
        rlo_rise = !prev[P_RLO] && ras_lo;
        rhi_rise = !prev[P_RHI] && ras_hi;
    end

    // Purpose: remember chip select so it must span the end of the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) cs_n_q <= 1'b1;
        else        cs_n_q <= cs_n;
    end

    // Purpose: write commits gated by chip select and inhibit.
    always_comb begin
        rtc_we = wr_rise && !cs_n && !cs_n_q && !inhibit;
        ram_we = rwe_rise && !inhibit;
    end

    // Purpose: latch the clock address on the latch pulse fall (mod 64).
    always_ff @(posedge clk) begin
        if (!rst_n)        rtc_addr <= '0;
        else if (ale_fall) rtc_addr <= ad_in[RAW-1:0];
    end

    // Purpose: assemble the RAM address from its two strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_addr <= '0;
        end else begin
            if (rlo_rise) ram_addr[DW-1:0]  <= ad_in;
            if (rhi_rise) ram_addr[MAW-1:DW] <= ad_in[HI_W-1:0];
        end
    end

    rtc_regfile #(.DW(DW), .AW(RAW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(rtc_we), .waddr(rtc_addr),
        .wdata(ad_in), .raddr(rtc_addr), .rdata(rtc_rdata)
    );

    byte_ram #(.DW(DW), .AW(MAW)) u_ram (
        .clk(clk), .we(ram_we), .waddr(ram_addr),
        .wdata(ad_in), .raddr(ram_addr), .rdata(ram_rdata)
    );

    // Purpose: bus drive enable and read data, clock side first.
    always_comb begin
        rtc_rd = !rd_n && !cs_n;
        ad_oe  = (rtc_rd || !roe_n) && !inhibit;
        if (!ad_oe)      ad_out = '0;
        else if (rtc_rd) ad_out = rtc_rdata;
        else             ad_out = ram_rdata;
    end

    AST_OE_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |-> !ad_oe); // R9
    AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n && roe_n) |-> !ad_oe); // R3
    AST_RTC_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(prev[P_ALE] && !ale) |=> $stable(rtc_addr)); // R1
    AST_RAM_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !((!prev[P_RLO] && ras_lo) || (!prev[P_RHI] && ras_hi)) |=> $stable(ram_addr)); // R4
endmodule

// File: tb/tb_mux_bus_dual_ram_if.sv
module tb_mux_bus_dual_ram_if;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ad_in = '0;
    logic [7:0] ad_out;
    logic       ad_oe;
    logic       ale = 0, rd_n = 1, wr_n = 1, cs_n = 1;
    logic       ras_lo = 0, ras_hi = 0, roe_n = 1, rwe_n = 1, inhibit = 0;
    int tests = 0, fails = 0;
    logic [7:0] v;

    always #4 clk = ~clk;

    mux_bus_dual_ram_if dut (
        .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .cs_n(cs_n), .ras_lo(ras_lo),
        .ras_hi(ras_hi), .roe_n(roe_n), .rwe_n(rwe_n), .inhibit(inhibit)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic rtc_latch(input logic [7:0] a);
        @(negedge clk); ad_in = a; ale = 1;
        @(negedge clk); ale = 0;
        @(negedge clk);
    endtask

    task automatic rtc_write(input logic [7:0] a, input logic [7:0] d, input logic use_cs);
        rtc_latch(a);
        cs_n = !use_cs; ad_in = d; wr_n = 0;
        @(negedge clk); wr_n = 1;
        @(negedge clk); cs_n = 1;
    endtask

    task automatic rtc_read(input logic [7:0] a, output logic [7:0] d);
        rtc_latch(a);
        cs_n = 0; rd_n = 0; #2; d = ad_out;
        @(negedge clk); rd_n = 1; cs_n = 1;
    endtask

    task automatic ram_set_addr(input logic [11:0] a);
        @(negedge clk); ad_in = a[7:0]; ras_lo = 1;
        @(negedge clk); ras_lo = 0; ad_in = {4'h0, a[11:8]}; ras_hi = 1;
        @(negedge clk); ras_hi = 0;
    endtask

    task automatic ram_write(input logic [11:0] a, input logic [7:0] d);
        ram_set_addr(a);
        ad_in = d; rwe_n = 0;
        @(negedge clk); rwe_n = 1;
        @(negedge clk);
    endtask

    task automatic ram_read(input logic [11:0] a, output logic [7:0] d);
        ram_set_addr(a);
        roe_n = 0; #2; d = ad_out;
        @(negedge clk); roe_n = 1;
    endtask

    task automatic t_reset;
        @(negedge clk); #1;
        check("R10 oe after reset", {7'd0, ad_oe}, 8'h00);
        rtc_read(8'd13, v); check("R10 reg13 reset", v, 8'h80);
        rtc_read(8'd0, v);  check("R10 reg0 reset", v, 8'h00);
        rtc_read(8'd40, v); check("R10 reg40 reset", v, 8'h00);
    endtask

    task automatic t_basic;
        rtc_write(8'd5, 8'h3C, 1);  rtc_read(8'd5, v);  check("R8 reg5", v, 8'h3C);
        rtc_write(8'd63, 8'hA5, 1); rtc_read(8'd63, v); check("R8 reg63", v, 8'hA5);
        rtc_write(8'd11, 8'hFF, 1); rtc_read(8'd11, v); check("R8 reg11", v, 8'hFF);
        rtc_read(8'h45, v); check("R1 alias 0x45 to 5", v, 8'h3C);
        rtc_write(8'hC7, 8'h19, 1); rtc_read(8'd7, v); check("R1 alias write 0xC7", v, 8'h19);
    endtask

    task automatic t_chip_select;
        rtc_write(8'd30, 8'h66, 1);
        rtc_write(8'd30, 8'h99, 0);
        rtc_read(8'd30, v); check("R2 no write without cs", v, 8'h66);
        rtc_write(8'd33, 8'h4E, 1);
        rtc_latch(8'd33);          // latched with cs_n high
        rtc_latch(8'd30);
        @(negedge clk); ad_in = 8'd33; ale = 1;
        @(negedge clk); ale = 0;
        @(negedge clk); cs_n = 0; rd_n = 0; #2;
        check("R1 latch without cs", ad_out, 8'h4E);
        @(negedge clk); rd_n = 1; cs_n = 1;
    endtask

    task automatic t_read_only;
        rtc_write(8'd12, 8'h5F, 1); rtc_read(8'd12, v); check("R6 reg12 ro", v, 8'h00);
        rtc_write(8'd13, 8'h11, 1); rtc_read(8'd13, v); check("R6 reg13 ro", v, 8'h80);
        rtc_write(8'd10, 8'hA6, 1); rtc_read(8'd10, v); check("R7 reg10 bit7", v, 8'h26);
    endtask

    task automatic t_ram;
        ram_write(12'h000, 8'h12); ram_write(12'hFFF, 8'hED); ram_write(12'h8A3, 8'h7E);
        ram_read(12'h000, v); check("R5 ram 000", v, 8'h12);
        ram_read(12'hFFF, v); check("R4 ram FFF", v, 8'hED);
        ram_read(12'h8A3, v); check("R4 ram 8A3", v, 8'h7E);
        ram_read(12'h0A3, v); check("R4 upper nibble distinct", v !== 8'h7E ? 8'h01 : 8'h00, 8'h01);
    endtask

    task automatic t_priority;
        rtc_latch(8'd5); ram_set_addr(12'h8A3);
        cs_n = 0; rd_n = 0; roe_n = 0; #2;
        check("R3 clock read wins", ad_out, 8'h3C);
        check("R3 oe on", {7'd0, ad_oe}, 8'h01);
        @(negedge clk); rd_n = 1; cs_n = 1; roe_n = 1; #2;
        check("R3 oe off when idle", {7'd0, ad_oe}, 8'h00);
    endtask

    task automatic t_inhibit;
        rtc_write(8'd7, 8'h22, 1);
        ram_write(12'h123, 8'h44);
        inhibit = 1;
        rtc_write(8'd7, 8'h11, 1);
        ram_write(12'h123, 8'h55);
        cs_n = 0; rd_n = 0; roe_n = 0; #2;
        check("R9 oe low under inhibit", {7'd0, ad_oe}, 8'h00);
        @(negedge clk); rd_n = 1; cs_n = 1; roe_n = 1; inhibit = 0;
        rtc_read(8'd7, v);     check("R9 clock write blocked", v, 8'h22);
        ram_read(12'h123, v);  check("R9 ram write blocked", v, 8'h44);
    endtask

    task automatic t_same_cycle;
        rtc_latch(8'd20);
        cs_n = 0; ad_in = 8'h5A; wr_n = 0;
        @(negedge clk); wr_n = 1; ras_lo = 1;      // both sample 0x5A on the next edge
        @(negedge clk); cs_n = 1; ras_lo = 0; ad_in = 8'h03; ras_hi = 1;
        @(negedge clk); ras_hi = 0; ad_in = 8'h77; rwe_n = 0;
        @(negedge clk); rwe_n = 1;
        @(negedge clk);
        rtc_read(8'd20, v);   check("R11 clock write with strobe", v, 8'h5A);
        ram_read(12'h35A, v); check("R11 ram addr from same cycle", v, 8'h77);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_basic();
        t_chip_select();
        t_read_only();
        t_ram();
        t_priority();
        t_inhibit();
        t_same_cycle();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule